// File: doc/BRIEF.md
# Clocked Serial Burst Port

This block moves bursts of 8-bit frames over a clock-synchronous serial link. It uses an eight-slot buffer that serves both directions. The host fills the slots, names a burst length and issues one start command. The block then shifts one byte from each slot in turn, starting at slot zero. It stores each incoming byte back into the slot its outgoing byte came from. After the last byte it raises a completion flag, with no host action needed between bytes.

The serial clock can come from the block or from outside. As clock master the block drives a clock whose half period is a programmable number of system cycles. As clock slave it follows an external clock, which it first passes through a two-stage synchronizer. An optional select mode lets an active-low select input frame the burst. While the select is high, no new byte begins and both serial outputs are released. If the select rises partway through a byte, that byte is dropped and the burst ends with an abort flag.

Top module: `sync_serial_burst`

## Requirements
- R1: Each frame is 8 bits, sent most significant bit first. `sdo` changes only in response to a falling serial clock edge, and incoming data is taken on the rising edge.
- R2: A start with `burstLen` = n transfers exactly n+1 bytes, using slots 0 to n in increasing order. Slots above n are left unchanged.
- R3: The byte received during the k-th frame of a burst is written into slot k. `rdData` always shows the slot selected by `rdIdx`, with no added latency.
- R4: When the last byte of a burst completes, `busy` falls and `done` rises. A start clears both `done` and `abort`.
- R5: In master mode the serial clock has a period of 2·`halfDiv` system cycles, and a `halfDiv` of 0 acts as 1. The clock idles high between bursts, and `sckOe` is 1 unless the select releases the pins.
- R6: In slave mode `sckOe` is 0. `sckIn`, `sdi` and `csN` are each taken through a two-stage synchronizer.
- R7: With `csMode` = 1 and `csN` high, no byte begins. A burst that is started waits with `busy` = 1, and no clock edges are produced, until `csN` goes low.
- R8: With `csMode` = 1 and synchronized `csN` high, both `sckOe` and `sdoOe` are 0. With `csMode` = 0, `sdoOe` is 1.
- R9: If `csN` rises in the middle of a byte in select mode, the burst ends with `abort` = 1, `done` = 0 and `busy` = 0. The partial byte is not written to any slot.
- R10: A start while `busy` is 1 is ignored, and so is a host write while `busy` is 1.
- R11: Between bytes and after a burst, `sdo` holds the last bit it sent, which is bit 0 of the final byte.
- R12: If `csN` rises in the same cycle as the rising edge that completes a byte, that byte counts as complete. When it is the last byte, the burst ends with `done` = 1 and `abort` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| masterMode | input | 1 | 1: the block drives the serial clock; 0: it follows `sckIn` |
| csMode | input | 1 | 1: `csN` frames the burst |
| halfDiv | input | 8 | Master clock half period in system cycles |
| burstLen | input | 3 | Burst length minus one |
| start | input | 1 | One-cycle start command |
| wrEn | input | 1 | Host slot write enable |
| wrIdx | input | 3 | Host slot write index |
| wrData | input | 8 | Host slot write data |
| rdIdx | input | 3 | Host slot read index |
| rdData | output | 8 | Contents of slot `rdIdx` |
| sckIn | input | 1 | External serial clock (slave mode) |
| sckOut | output | 1 | Generated serial clock |
| sckOe | output | 1 | Output enable for the serial clock |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdoOe | output | 1 | Output enable for serial data |
| csN | input | 1 | Active-low select |
| busy | output | 1 | Burst in progress |
| done | output | 1 | Last burst completed |
| abort | output | 1 | Last burst aborted by the select |

## Verification
Two events can fall in the same system cycle: the rising clock edge that completes a byte and the select release. The bench provokes this in slave mode by raising `sckIn` and `csN` at the same instant. Both pass through synchronizers of equal depth, so both arrive in the same cycle. The case passes when `done` is set, `abort` stays clear, and slot 0 holds the byte that was shifted in. A related pair is also checked: a release that lands mid-byte must abort the burst and leave the slot's original contents in place.

// File: rtl/ssp_pkg.sv
`timescale 1ns/1ps
package ssp_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic loadTx;    // load transmit shifter from txSlot
    logic shiftOut;  // falling edge: present next bit
    logic sampleIn;  // rising edge: take one bit
    logic commitRx;  // byte finished: store into rxSlot
    logic hostLock;  // burst running, host writes blocked
    logic rxBit;     // aligned serial input bit
  } ssp_strobe_t;
endpackage

// File: rtl/ssp_ctrl.sv
`timescale 1ns/1ps
module ssp_ctrl
  import ssp_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8,
  parameter int DIV_W  = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int BIT_W = $clog2(DATA_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [PTR_W-1:0] burstLen,
  input  logic             masterMode,
  input  logic             csMode,
  input  logic [DIV_W-1:0] halfDiv,
  input  logic             sckIn,
  input  logic             sdi,
  input  logic             csN,
  output ssp_strobe_t      strobe,
  output logic [PTR_W-1:0] txSlot,
  output logic [PTR_W-1:0] rxSlot,
  output logic             sckOut,
  output logic             sckOe,
  output logic             sdoOe,
  output logic             busy,
  output logic             done,
  output logic             abort
);
  logic [1:0] sckSync, sdiSync, csSync;
  logic sckPrev, sckGen, busyR, doneR, abortR, inByte;
  logic [DIV_W-1:0] divCnt, halfEff;
  logic [BIT_W-1:0] bitCnt;
  logic [CNT_W-1:0] count;
  logic [PTR_W-1:0] ptr;
  logic sckS, csHi, gate, tick, fall, rise, byteDone, lastByte, abortNow, startNow;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sckSync <= 2'b11;
      sdiSync <= 2'b00;
      csSync  <= 2'b11;
    end else begin
      sckSync <= {sckSync[0], sckIn};
      sdiSync <= {sdiSync[0], sdi};
      csSync  <= {csSync[0], csN};
    end
  end

  assign sckS     = sckSync[1];
  assign csHi     = csSync[1];
  assign gate     = !csMode || !csHi;
  assign halfEff  = (halfDiv == '0) ? DIV_W'(1) : halfDiv;
  assign tick     = masterMode && busyR && gate && (divCnt == halfEff - DIV_W'(1));
  assign fall     = masterMode ? (tick && sckGen) : (busyR && gate && sckPrev && !sckS);
  assign rise     = masterMode ? (tick && !sckGen && inByte) : (busyR && inByte && !sckPrev && sckS);
  assign byteDone = rise && (bitCnt == BIT_W'(DATA_W - 1));
  assign lastByte = (count == CNT_W'(1));
  assign abortNow = busyR && csMode && csHi && inByte && !byteDone;
  assign startNow = start && !busyR;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sckPrev <= 1'b1;
      sckGen  <= 1'b1;
      divCnt  <= '0;
      busyR   <= 1'b0;
      doneR   <= 1'b0;
      abortR  <= 1'b0;
      inByte  <= 1'b0;
      bitCnt  <= '0;
      count   <= '0;
      ptr     <= '0;
    end else begin
      sckPrev <= sckS;
      if (startNow) begin
        busyR  <= 1'b1;
        doneR  <= 1'b0;
        abortR <= 1'b0;
        count  <= CNT_W'(burstLen) + CNT_W'(1);
        ptr    <= '0;
        bitCnt <= '0;
        inByte <= 1'b0;
        divCnt <= '0;
        sckGen <= 1'b1;
      end else if (busyR) begin
        if (abortNow) begin
          busyR  <= 1'b0;
          abortR <= 1'b1;
          inByte <= 1'b0;
          bitCnt <= '0;
          sckGen <= 1'b1;
          divCnt <= '0;
        end else begin
          if (masterMode && gate) begin
            if (tick) begin
              divCnt <= '0;
              sckGen <= ~sckGen;
            end else begin
              divCnt <= divCnt + DIV_W'(1);
            end
          end
          if (fall) inByte <= 1'b1;
          if (rise) bitCnt <= bitCnt + BIT_W'(1);
          if (byteDone) begin
            inByte <= 1'b0;
            count  <= count - CNT_W'(1);
            ptr    <= ptr + PTR_W'(1);
            if (lastByte) begin
              busyR <= 1'b0;
              doneR <= 1'b1;
            end
          end
        end
      end
    end
  end

  always_comb begin
    strobe.loadTx   = startNow || (byteDone && !lastByte);
    strobe.shiftOut = fall;
    strobe.sampleIn = rise && !abortNow;
    strobe.commitRx = byteDone;
    strobe.hostLock = busyR;
    strobe.rxBit    = masterMode ? sdi : sdiSync[1];
  end

  assign txSlot = startNow ? '0 : ptr + PTR_W'(1);
  assign rxSlot = ptr;
  assign sckOut = masterMode ? sckGen : 1'b1;
  assign sckOe  = masterMode && !(csMode && csHi);
  assign sdoOe  = !(csMode && csHi);
  assign busy   = busyR;
  assign done   = doneR;
  assign abort  = abortR;

  // R4
  done_abort_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(doneR && abortR));
  // R5
  sck_idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busyR |-> sckGen);
  // R2
  count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busyR |-> (count >= CNT_W'(1) && count <= CNT_W'(DEPTH)));
  // R10
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busyR && start && !rise) |=> (count == $past(count)));
  // R9
  abort_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(abortR) |-> (!busyR && !doneR));
endmodule

// File: rtl/ssp_datapath.sv
`timescale 1ns/1ps
module ssp_datapath
  import ssp_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ssp_strobe_t       strobe,
  input  logic [PTR_W-1:0]  txSlot,
  input  logic [PTR_W-1:0]  rxSlot,
  input  logic              wrEn,
  input  logic [PTR_W-1:0]  wrIdx,
  input  logic [DATA_W-1:0] wrData,
  input  logic [PTR_W-1:0]  rdIdx,
  output logic [DATA_W-1:0] rdData,
  output logic              sdo
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] txSh, rxSh, rxWord;
  logic sdoR;

  assign rxWord = {rxSh[DATA_W-2:0], strobe.rxBit};

  for (genvar s = 0; s < DEPTH; s++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mem[s] <= '0;
      else if (strobe.commitRx && rxSlot == PTR_W'(s)) mem[s] <= rxWord;
      else if (wrEn && !strobe.hostLock && wrIdx == PTR_W'(s)) mem[s] <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txSh <= '0;
      rxSh <= '0;
      sdoR <= 1'b1;
    end else begin
      if (strobe.loadTx) txSh <= mem[txSlot];
      else if (strobe.shiftOut) txSh <= {txSh[DATA_W-2:0], 1'b0};
      if (strobe.shiftOut) sdoR <= txSh[DATA_W-1];
      if (strobe.sampleIn) rxSh <= rxWord;
    end
  end

  assign rdData = mem[rdIdx];
  assign sdo    = sdoR;

  // R11
  sdo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.shiftOut |=> $stable(sdoR));
endmodule

// File: rtl/sync_serial_burst.sv
`timescale 1ns/1ps
module sync_serial_burst
  import ssp_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8,
  parameter int DIV_W  = 8,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              masterMode,
  input  logic              csMode,
  input  logic [DIV_W-1:0]  halfDiv,
  input  logic [PTR_W-1:0]  burstLen,
  input  logic              start,
  input  logic              wrEn,
  input  logic [PTR_W-1:0]  wrIdx,
  input  logic [DATA_W-1:0] wrData,
  input  logic [PTR_W-1:0]  rdIdx,
  output logic [DATA_W-1:0] rdData,
  input  logic              sckIn,
  output logic              sckOut,
  output logic              sckOe,
  input  logic              sdi,
  output logic              sdo,
  output logic              sdoOe,
  input  logic              csN,
  output logic              busy,
  output logic              done,
  output logic              abort
);
  ssp_strobe_t strobe;
  logic [PTR_W-1:0] txSlot, rxSlot;

  ssp_ctrl #(.DATA_W(DATA_W), .DEPTH(DEPTH), .DIV_W(DIV_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .burstLen(burstLen),
    .masterMode(masterMode), .csMode(csMode), .halfDiv(halfDiv),
    .sckIn(sckIn), .sdi(sdi), .csN(csN), .strobe(strobe),
    .txSlot(txSlot), .rxSlot(rxSlot), .sckOut(sckOut), .sckOe(sckOe),
    .sdoOe(sdoOe), .busy(busy), .done(done), .abort(abort)
  );

  ssp_datapath #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .txSlot(txSlot),
    .rxSlot(rxSlot), .wrEn(wrEn), .wrIdx(wrIdx), .wrData(wrData),
    .rdIdx(rdIdx), .rdData(rdData), .sdo(sdo)
  );
endmodule

// File: tb/sync_serial_burst_bench.sv
`timescale 1ns/1ps
module sync_serial_burst_bench;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, masterMode, csMode, start, wrEn, sckIn, csN, sdiM, clrReq;
  logic [7:0] halfDiv, wrData, rdData;
  logic [2:0] burstLen, wrIdx, rdIdx;
  logic sckOut, sckOe, sdo, sdoOe, busy, done, abort;

  sync_serial_burst u_sync_serial_burst (
    .clk(clk), .rst_n(rst_n), .masterMode(masterMode), .csMode(csMode),
    .halfDiv(halfDiv), .burstLen(burstLen), .start(start), .wrEn(wrEn),
    .wrIdx(wrIdx), .wrData(wrData), .rdIdx(rdIdx), .rdData(rdData),
    .sckIn(sckIn), .sckOut(sckOut), .sckOe(sckOe), .sdi(sdiM), .sdo(sdo),
    .sdoOe(sdoOe), .csN(csN), .busy(busy), .done(done), .abort(abort)
  );

  int compared = 0, mismatched = 0;
  logic [7:0] txPat [8], rxPat [8], cap [8];
  int capBits, sdiBits, lastFallCyc, fallPeriod, cyc = 0;
  logic prevLine = 1'b1;
  wire sckLine = masterMode ? sckOut : sckIn;

  always @(posedge clk) cyc <= cyc + 1;

  // serial partner model: feeds rxPat on falls, captures sdo on rises
  always @(negedge clk) begin
    if (clrReq) begin
      capBits = 0; sdiBits = 0; fallPeriod = 0; lastFallCyc = 0;
    end else if (sckLine !== prevLine) begin
      if (!sckLine) begin
        if (sdiBits < 64) sdiM <= rxPat[sdiBits / 8][7 - sdiBits % 8];
        sdiBits++;
        fallPeriod = cyc - lastFallCyc;
        lastFallCyc = cyc;
      end else begin
        if (capBits < 64) cap[capBits / 8][7 - capBits % 8] = sdo;
        capBits++;
      end
    end
    prevLine = sckLine;
  end

  // {master, csMode, halfDiv[3:0], burstLen[2:0], seed[7:0]}
  localparam logic [16:0] VECS [6] = '{
    {1'b1, 1'b0, 4'd1, 3'd7, 8'hA5},
    {1'b1, 1'b0, 4'd2, 3'd0, 8'h3C},
    {1'b1, 1'b1, 4'd3, 3'd3, 8'h5A},
    {1'b0, 1'b0, 4'd0, 3'd4, 8'hC3},
    {1'b0, 1'b1, 4'd0, 3'd7, 8'h81},
    {1'b1, 1'b0, 4'd0, 3'd2, 8'h7E}
  };

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clearModel();
    clrReq = 1'b1; tick(1); clrReq = 1'b0;
  endtask

  task automatic hostWrite(input int idx, input logic [7:0] d);
    wrEn = 1'b1; wrIdx = idx[2:0]; wrData = d; tick(1); wrEn = 1'b0;
  endtask

  task automatic readSlot(input int idx, output logic [7:0] d);
    rdIdx = idx[2:0]; #1; d = rdData;
  endtask

  task automatic loadPatterns(input logic [7:0] seed);
    for (int i = 0; i < 8; i++) begin
      txPat[i] = seed ^ 8'(i * 29);
      rxPat[i] = ~seed ^ 8'(i * 83 + 7);
      hostWrite(i, txPat[i]);
    end
  endtask

  task automatic pulseStart(input int len);
    burstLen = len[2:0]; start = 1'b1; tick(1); start = 1'b0;
  endtask

  task automatic slaveBits(input int n, input int half);
    for (int b = 0; b < n; b++) begin
      sckIn = 1'b0; tick(half); sckIn = 1'b1; tick(half);
    end
  endtask

  task automatic waitIdle();
    int t = 0;
    while (busy && t < 5000) begin tick(1); t++; end
  endtask

  initial begin
    logic [7:0] d;
    rst_n = 1'b0; masterMode = 1'b1; csMode = 1'b0; halfDiv = 8'd1;
    burstLen = '0; start = 1'b0; wrEn = 1'b0; wrIdx = '0; wrData = '0;
    rdIdx = '0; sckIn = 1'b1; csN = 1'b1; sdiM = 1'b0; clrReq = 1'b0;
    tick(5);
    chk("R4 reset busy", busy, 0);
    chk("R4 reset done", done, 0);
    chk("R9 reset abort", abort, 0);
    chk("R5 reset sckOut idle high", sckOut, 1);
    chk("R8 reset sdoOe", sdoOe, 1);
    rst_n = 1'b1; tick(2);

    // vector table
    for (int v = 0; v < 6; v++) begin
      logic [16:0] e;
      int len, h;
      e = VECS[v];
      len = int'(e[10:8]);
      h = int'(e[14:11]);
      masterMode = e[16]; csMode = e[15]; halfDiv = 8'(h);
      csN = e[15] ? 1'b0 : 1'b1;
      tick(4);
      loadPatterns(e[7:0]);
      clearModel();
      pulseStart(len);
      if (e[16]) waitIdle();
      else slaveBits((len + 1) * 8, 6);
      tick(4);
      chk("R4 done after burst", done, 1);
      chk("R4 abort clear", abort, 0);
      chk("R4 busy low", busy, 0);
      chk("R2 bit count", capBits, (len + 1) * 8);
      for (int i = 0; i < 8; i++) begin
        readSlot(i, d);
        if (i <= len) begin
          chk("R1 sent byte msb first", cap[i], txPat[i]);
          chk("R3 received byte in slot", d, rxPat[i]);
        end else begin
          chk("R2 unused slot kept", d, txPat[i]);
        end
      end
      chk("R11 sdo holds last bit", sdo, txPat[len][0]);
      if (e[16]) begin
        chk("R5 sckOe master", sckOe, 1);
        chk("R5 sckOut idle high", sckOut, 1);
        chk("R5 clock period", fallPeriod, 2 * ((h == 0) ? 1 : h));
      end else begin
        chk("R6 sckOe slave", sckOe, 0);
      end
    end

    // R10: start and host write while busy are ignored
    masterMode = 1'b1; csMode = 1'b0; halfDiv = 8'd2; csN = 1'b1; tick(3);
    loadPatterns(8'h99); clearModel();
    pulseStart(1); tick(3);
    pulseStart(7);
    hostWrite(5, 8'hEE);
    waitIdle(); tick(3);
    chk("R10 restart ignored bit count", capBits, 16);
    readSlot(5, d);
    chk("R10 host write ignored", d, txPat[5]);
    chk("R10 done", done, 1);

    // R7 / R8: select high holds the burst and releases the pins
    masterMode = 1'b1; csMode = 1'b1; halfDiv = 8'd1; csN = 1'b1; tick(3);
    loadPatterns(8'h42); clearModel();
    pulseStart(0); tick(30);
    chk("R7 waiting busy", busy, 1);
    chk("R7 no clock edges", capBits + sdiBits, 0);
    chk("R7 clock parked high", sckOut, 1);
    chk("R8 sckOe released", sckOe, 0);
    chk("R8 sdoOe released", sdoOe, 0);
    csN = 1'b0; tick(3);
    waitIdle(); tick(3);
    chk("R7 completes after select low", done, 1);
    chk("R7 one byte sent", cap[0], txPat[0]);
    chk("R8 sckOe restored", sckOe, 1);
    chk("R8 sdoOe restored", sdoOe, 1);

    // R9: select rises mid-byte
    masterMode = 1'b0; csMode = 1'b1; csN = 1'b0; tick(3);
    loadPatterns(8'h6D); clearModel();
    pulseStart(2); slaveBits(3, 6);
    csN = 1'b1; tick(6);
    chk("R9 abort set", abort, 1);
    chk("R9 done clear", done, 0);
    chk("R9 busy low", busy, 0);
    readSlot(0, d);
    chk("R9 partial byte discarded", d, txPat[0]);
    chk("R8 sdoOe released after abort", sdoOe, 0);

    // R12: release in the same cycle as the final rising edge
    csN = 1'b0; tick(3);
    loadPatterns(8'hB4); clearModel();
    pulseStart(0); slaveBits(7, 6);
    sckIn = 1'b0; tick(6);
    sckIn = 1'b1; csN = 1'b1; tick(6);
    chk("R12 done on coincident release", done, 1);
    chk("R12 abort clear (R4 start cleared it)", abort, 0);
    readSlot(0, d);
    chk("R12 byte stored", d, rxPat[0]);
    chk("R12 byte sent", cap[0], txPat[0]);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule